// File: doc/BRIEF.md
# Chainable Serial Command Port

This block is the serial front end of a multi-channel driver's control logic. A host selects the device by pulling the active-low select line low. It then clocks one 16-bit command word per device in on the data input, most significant bit first. During the same clocks the device returns a 16-bit status word on its data output. When the select line goes high again, the last 16 bits received are copied into a parallel command register, and a single-cycle strobe marks the update. The power stage and the fault detectors sit outside this block: they read the command word and drive the status inputs.

All serial inputs are oversampled by the core clock. Each one passes through a synchronizer of the same depth, so serial data and serial clock stay aligned. The leading status bit is a temperature warning that is passed to the output live, not latched. The rest of the status word is captured when the device is selected, so the host always reads the state from before the current frame. Several devices can share one select line when each data output feeds the next device's data input. The host then sends one word per device, starting with the word for the device farthest down the chain.

Top module: `chain_spi_port`

## Requirements
- R1: While the select line is high, serial clock edges do not change the shift path. A frame is only the traffic between a falling and the following rising edge of the select line.
- R2: From the moment the select line is seen low until the first falling serial-clock edge after a rising one, do_o carries ot_warn_i combinationally, with no register in the path.
- R3: The status word returned is {ot_warn_i, stat_i[14:0]} and is sent MSB first. Bits 14..0 are captured when the select line falls, so any change of stat_i during the frame does not appear.
- R4: di_i is sampled on rising serial-clock edges, MSB first. do_o changes only on falling serial-clock edges while selected. The serial clock idles low.
- R5: After a device has sent its 16 status bits, it re-emits each bit it received 16 bits earlier. With N devices in a chain and N*16 clocks, the word sent first ends up in the last device.
- R6: A frame whose bit count is zero or not a multiple of 16 is discarded, and cmd_o keeps its value.
- R7: Each accepted frame raises cmd_valid_o for exactly one core-clock cycle. cmd_o takes the last 16 bits received in that same cycle.
- R8: After reset, cmd_o equals CMD_RST (default 16'h0000, the standby state), cmd_valid_o is low, and do_o is low while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| cs_ni | input | 1 | Active-low device select |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, low when deselected |
| ot_warn_i | input | 1 | Live overtemperature warning, leading status bit |
| stat_i | input | 15 | Latched fault status, captured when the select line falls |
| cmd_o | output | 16 | Parallel command word |
| cmd_valid_o | output | 1 | One-cycle strobe when the command word updates |

## Verification
The hardest case to reach is the pass-through path. A device forwards its own status first and then the data it received 16 bits earlier. So the middle device of a chain must receive the first device's status, then a word meant for the last device, and then its own word, and it must keep only the last of these. The bench builds a chain of three instances and sends 48-bit frames of mixed words and status values. It checks that every device holds the right word and that the chain output returns the three status words in device order. Directed frames cover one word in a chain of three, a truncated 47-bit frame, an empty frame used to watch the live warning bit, and a status change in the middle of a frame.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/csp_shift.sv
module csp_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              di_i,
  input  logic              ot_warn_i,
  input  logic [WORD_W-2:0] stat_i,
  output logic              do_o,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_ok_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              any_q, first_q, do_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      any_q   <= 1'b0;
      first_q <= 1'b0;
      do_q    <= 1'b0;
    end else if (start_i) begin
      // leading bit is replaced by the live warning on the pin
      shreg_q <= {1'b0, stat_i};
      cnt_q   <= '0;
      any_q   <= 1'b0;
      first_q <= 1'b1;
      do_q    <= 1'b0;
    end else if (sel_i) begin
      if (rise_i) begin
        shreg_q <= {shreg_q[WORD_W-2:0], di_i};
        cnt_q   <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
        any_q   <= 1'b1;
      end
      if (fall_i && any_q) begin
        do_q    <= shreg_q[WORD_W-1];
        first_q <= 1'b0;
      end
    end
  end

  assign do_o       = sel_i ? (first_q ? ot_warn_i : do_q) : 1'b0;
  assign word_o     = shreg_q;
  assign frame_ok_o = any_q && (cnt_q == '0);

  // R1
  idle_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(shreg_q));

  // R4
  do_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !start_i && !fall_i) |=> $stable(do_q));
endmodule

// File: rtl/csp_cmd_reg.sv
module csp_cmd_reg #(
  parameter int unsigned       WORD_W  = 16,
  parameter logic [WORD_W-1:0] CMD_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic              ok_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= CMD_RST;
      valid_o <= 1'b0;
    end else begin
      valid_o <= end_i && ok_i;
      if (end_i && ok_i) cmd_o <= word_i;
    end
  end

  // R7
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o || $stable(cmd_o)));
endmodule

// File: rtl/chain_spi_port.sv
module chain_spi_port
  import csp_pkg::*;
#(
  parameter logic [WORD_W-1:0] CMD_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              di_i,
  output logic              do_o,
  input  logic              ot_warn_i,
  input  logic [WORD_W-2:0] stat_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              cmd_valid_o
);
  logic sclk_s, cs_s, di_s;
  logic sclk_d, sel_d;
  logic sel, start, stop, rise, fall;
  logic [WORD_W-1:0] word;
  logic frame_ok;

  csp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  csp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));
  csp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_di (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(di_i), .q_o(di_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel;
    end
  end

  assign sel   = !cs_s;
  assign start = sel && !sel_d;
  assign stop  = !sel && sel_d;
  assign rise  = sclk_s && !sclk_d;
  assign fall  = !sclk_s && sclk_d;

  csp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .start_i(start),
    .rise_i(rise), .fall_i(fall), .di_i(di_s), .ot_warn_i(ot_warn_i),
    .stat_i(stat_i), .do_o(do_o), .word_o(word), .frame_ok_o(frame_ok));

  csp_cmd_reg #(.WORD_W(WORD_W), .CMD_RST(CMD_RST)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .end_i(stop), .ok_i(frame_ok),
    .word_i(word), .cmd_o(cmd_o), .valid_o(cmd_valid_o));

  // R7
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(stop));

  // R8
  idle_do_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !do_o);
endmodule

// File: tb/chain_spi_port_tb.sv
module chain_spi_port_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int NV    = 4;
  // {A, B, C, S3, S2, S1}; A is sent first and lands in device 3
  localparam logic [95:0] VEC [NV] = '{
    {16'hA5C3, 16'h1234, 16'hFFFF, 16'h8001, 16'h7FFE, 16'h0F0F},
    {16'h0000, 16'h8000, 16'h0001, 16'h0000, 16'hFFFF, 16'h8000},
    {16'hDEAD, 16'hBEEF, 16'hCAFE, 16'h5555, 16'hAAAA, 16'h3C3C},
    {16'h7F80, 16'h00FF, 16'hC001, 16'hFFFF, 16'h0000, 16'h1248}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, di = 1'b0;
  logic [2:0]  dout, din, warn = '0;
  logic [44:0] stat = '0;
  logic [47:0] cmd;
  logic [2:0]  vld;
  logic [47:0] cap;
  int tests = 0, fails = 0;
  int stb [3] = '{0, 0, 0};
  int stb0 [3];

  always #(CLK_P/2) clk = ~clk;

  assign din = {dout[1], dout[0], di};

  chain_spi_port dut_i [2:0] (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .di_i(din),
    .do_o(dout), .ot_warn_i(warn), .stat_i(stat), .cmd_o(cmd),
    .cmd_valid_o(vld));

  always @(posedge clk)
    for (int k = 0; k < 3; k++) if (vld[k]) stb[k]++;

  task automatic chk(input string req, input logic [47:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_stat(input logic [15:0] s3, s2, s1);
    warn = {s3[15], s2[15], s1[15]};
    stat = {s3[14:0], s2[14:0], s1[14:0]};
  endtask

  task automatic frame(input logic [47:0] data, input int n);
    cap = '0;
    cs_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < n; i++) begin
      di = data[n-1-i];
      wclk(HALF);
      cap = {cap[46:0], dout[2]};
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2*HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wclk(3);
    // R8 reset state
    chk("R8 cmd", cmd, 48'h0);
    chk("R8 strobe/do", {45'h0, vld | dout}, 48'h0);
    rst_n = 1'b1;
    wclk(4);
    // R1 serial clocks while deselected are ignored
    for (int i = 0; i < 5; i++) begin
      di = 1'b1; sclk = 1'b1; wclk(HALF); sclk = 1'b0; wclk(HALF);
    end
    chk("R1 no shift deselected", cmd, 48'h0);

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 3; k++) stb0[k] = stb[k];
      set_stat(VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);
      wclk(2);
      frame(VEC[v][95:48], 48);
      chk("R5 device3 holds A", {32'h0, cmd[47:32]}, {32'h0, VEC[v][95:80]});
      chk("R5 device2 holds B", {32'h0, cmd[31:16]}, {32'h0, VEC[v][79:64]});
      chk("R1 R4 device1 holds C", {32'h0, cmd[15:0]}, {32'h0, VEC[v][63:48]});
      chk("R3 R5 chain status", cap, VEC[v][47:0]);
      chk("R7 one strobe each",
          48'((stb[0]-stb0[0]) + 2*(stb[1]-stb0[1]) + 4*(stb[2]-stb0[2])), 48'd7);
    end

    // R5 single word: downstream devices take upstream status
    set_stat(16'h0000, 16'hC1A0, 16'h9A5A);
    wclk(2);
    frame({32'h0, 16'h4E21}, 16);
    chk("R5 single word", cmd, {16'hC1A0, 16'h9A5A, 16'h4E21});

    // R6 truncated frame discarded
    for (int k = 0; k < 3; k++) stb0[k] = stb[k];
    frame(48'hFFFF_FFFF_FFFF, 47);
    chk("R6 cmd held", cmd, {16'hC1A0, 16'h9A5A, 16'h4E21});
    chk("R6 no strobe", 48'((stb[0]-stb0[0]) + (stb[1]-stb0[1]) + (stb[2]-stb0[2])), 48'd0);

    // R2 live warning before first clock; empty frame R6
    for (int k = 0; k < 3; k++) stb0[k] = stb[k];
    cs_n = 1'b0;
    wclk(HALF);
    warn[2] = 1'b1; #1;
    chk("R2 live high", {47'h0, dout[2]}, 48'd1);
    wclk(1);
    warn[2] = 1'b0; #1;
    chk("R2 live low", {47'h0, dout[2]}, 48'd0);
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2*HALF);
    chk("R6 empty frame", 48'((stb[0]-stb0[0]) + (stb[1]-stb0[1]) + (stb[2]-stb0[2])), 48'd0);
    chk("R8 do low deselected", {45'h0, dout}, 48'h0);

    // R3 status captured at select, later change not seen
    set_stat(16'h1357, 16'h0000, 16'h0000);
    wclk(2);
    fork
      frame(48'h0, 48);
      begin wclk(5*HALF); stat[44:30] = 15'h7ACE; end
    join
    chk("R3 pre-frame status", {32'h0, cap[47:32]}, {32'h0, 16'h1357});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule